// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel serial audio stream from an external clock master and turns it into parallel 24-bit left and right samples. The stream uses three wires: a bit clock, a word-select clock that marks the left and right halves of each frame, and a data line. All three are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block finds rising bit-clock edges in the system clock domain. The block generates no clock of its own.

A 2-bit format code chooses one of four framings at run time. The choices are a one-bit-delayed (I²S) layout, a left-justified layout, and two right-justified widths, 24 and 16 bits. In the right-justified layouts the sample sits at the end of each half. When a left half and the right half after it have both been received cleanly, the block updates both parallel outputs together and pulses a strobe for one cycle. A half that carries too few bit clocks for the chosen format raises a one-cycle framing-error pulse, and that stereo pair is dropped.

The controller has four states. In `ST_IDLE` it waits for the first bit-clock edge after reset. In `ST_HUNT` it waits for the first word-select change. `ST_LEFT` and `ST_RIGHT` are the two channel halves. The transitions are:
- `ST_IDLE` to `ST_HUNT` on the first bit.
- `ST_HUNT` to `ST_LEFT` or `ST_RIGHT` on the first word-select change, chosen by the new level.
- `ST_LEFT` to `ST_RIGHT` on each later change.
- `ST_RIGHT` to `ST_LEFT` on each later change.

Every change seen while in `ST_LEFT` or `ST_RIGHT` closes the half that just ended. The format code must be held steady while the block is out of reset.

Top module: `audio_serial_rx`

## Requirements
- R1: The format code selects the framing: 00 one-bit-delayed (I²S) with left channel on word-select low; 01 right-justified 24-bit; 10 left-justified; 11 right-justified 16-bit. In codes 01, 10 and 11 the left channel is word-select high.
- R2: The data line is sampled at rising bit-clock edges, taken through two-flop synchronizers into the system clock domain. Every sample is sent MSB first. A half's slot 0 is the bit sampled at the first rising edge after word-select changes.
- R3: Code 10: output bit 23-k equals slot k for k < 24. Slots beyond 23 are ignored. Output bits with no slot in a short half are zero.
- R4: Code 00: output bit 23-k equals slot k+1. Slot 0 and slots beyond 24 are ignored. Output bits with no slot are zero.
- R5: Code 01: output bit k equals the slot k places before the last slot of the half. Only the final 24 slots count.
- R6: Code 11: the last 16 slots of the half form bits 15..0, and bit 15 is copied into output bits 23..16.
- R7: After a right half closes cleanly and was preceded by a clean left half, `pair_valid` is high for exactly one cycle. `left_out` and `right_out` take the new pair in the same cycle and hold at all other times.
- R8: Minimum bit clocks per half: 16 for codes 00 and 10, 24 for codes 01 and 11. A shorter half gives a one-cycle `frame_err` pulse when it closes, and no pair is produced from it.
- R9: After reset, the partial half before the first word-select change is discarded. It produces neither a pair nor a framing error.
- R10: During reset, `left_out` and `right_out` are zero and `pair_valid` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock from the master |
| ws_in | input | 1 | Word-select (channel) clock from the master |
| sd_in | input | 1 | Serial data line |
| fmt_sel | input | 2 | Framing format code |
| left_out | output | 24 | Last complete left sample |
| right_out | output | 24 | Last complete right sample |
| pair_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |
| frame_err | output | 1 | One-cycle pulse when a half closes with too few bit clocks |

## Verification
A wrong controller state shows up at the ports within one half-frame. A left/right polarity error swaps the channels in the very next pair. A missed word-select change merges two halves, which appears as a framing error or a corrupted pair at the next close. A bit counter that is off by one moves every justified sample by one bit, so the first pair compared already differs. A wrong minimum count either drops a pair that should appear or lets through a pair that should be dropped, and the bench sees this through its running tallies of pairs and error pulses.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int SAMPLE_W_DEF = 24;
    localparam int SHORT_W_DEF  = 16;
    localparam int CNT_W_DEF    = 7;

    typedef enum logic [1:0] {
        FMT_I2S      = 2'b00,
        FMT_RJ_FULL  = 2'b01,
        FMT_LJ       = 2'b10,
        FMT_RJ_SHORT = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign lvl_o = sync_q;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_o[i] = sync_q[i] & ~last_q[i];

        // R2
        single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser
    import audio_rx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int SHORT_W  = SHORT_W_DEF,
    parameter int CNT_W    = CNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic                bit_i,
    input  logic                restart_i,
    input  fmt_e                fmt_i,
    output logic [SAMPLE_W-1:0] word_o,
    output logic [CNT_W-1:0]    cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               EXT_W   = SAMPLE_W - SHORT_W;

    logic [SAMPLE_W-1:0] rj_q;
    logic [SAMPLE_W-1:0] jw_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                delay1;
    logic [CNT_W-1:0]    idx;
    logic                in_win;

    assign delay1 = (fmt_i == FMT_I2S);
    assign idx    = cnt_q - CNT_W'(delay1);
    assign in_win = (cnt_q >= CNT_W'(delay1)) && (idx < CNT_W'(SAMPLE_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rj_q  <= '0;
            jw_q  <= '0;
        end else if (stb_i) begin
            if (restart_i) begin
                cnt_q <= CNT_W'(1);
                rj_q  <= {{(SAMPLE_W-1){1'b0}}, bit_i};
                jw_q  <= delay1 ? '0 : {bit_i, {(SAMPLE_W-1){1'b0}}};
            end else begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
                rj_q <= {rj_q[SAMPLE_W-2:0], bit_i};
                for (int i = 0; i < SAMPLE_W; i++) begin
                    if (in_win && idx == CNT_W'(SAMPLE_W-1-i)) jw_q[i] <= bit_i;
                end
            end
        end
    end

    always_comb begin
        unique case (fmt_i)
            FMT_RJ_FULL:  word_o = rj_q;
            FMT_RJ_SHORT: word_o = {{EXT_W{rj_q[SHORT_W-1]}}, rj_q[SHORT_W-1:0]};
            default:      word_o = jw_q;
        endcase
    end

    assign cnt_o = cnt_q;

    // R2
    restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && restart_i) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int SAMPLE_W     = SAMPLE_W_DEF,
    parameter int SHORT_W      = SHORT_W_DEF,
    parameter int CNT_W        = CNT_W_DEF,
    parameter int MIN_HALF_JST = 16,
    parameter int MIN_HALF_RJ  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic                sd_in,
    input  logic [1:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid,
    output logic                frame_err
);
    localparam int IN_W = 3;

    logic [IN_W-1:0]     s_lvl, s_rise;
    logic                bit_stb, ws_s, sd_s;
    fmt_e                fmt;
    rx_state_e           state_q, state_d;
    logic                ws_prev_q;
    logic                trans;
    logic                left_lvl;
    logic [CNT_W-1:0]    min_bits;
    logic                short_half;
    logic [SAMPLE_W-1:0] half_word;
    logic [CNT_W-1:0]    half_cnt;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                have_left_q;

    audio_rx_sync #(.W(IN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({bclk_in, ws_in, sd_in}),
        .lvl_o  (s_lvl),
        .rise_o (s_rise)
    );

    assign bit_stb = s_rise[2];
    assign ws_s    = s_lvl[1];
    assign sd_s    = s_lvl[0];
    assign fmt     = fmt_e'(fmt_sel);

    assign trans    = bit_stb && (state_q != ST_IDLE) && (ws_s != ws_prev_q);
    assign left_lvl = (fmt != FMT_I2S);

    always_comb begin
        unique case (fmt)
            FMT_RJ_FULL, FMT_RJ_SHORT: min_bits = CNT_W'(MIN_HALF_RJ);
            default:                   min_bits = CNT_W'(MIN_HALF_JST);
        endcase
    end

    audio_rx_deser #(
        .SAMPLE_W (SAMPLE_W),
        .SHORT_W  (SHORT_W),
        .CNT_W    (CNT_W)
    ) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (bit_stb),
        .bit_i     (sd_s),
        .restart_i (trans),
        .fmt_i     (fmt),
        .word_o    (half_word),
        .cnt_o     (half_cnt)
    );

    assign short_half = (half_cnt < min_bits);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bit_stb) state_d = ST_HUNT;
            ST_HUNT:  if (trans)   state_d = (ws_s == left_lvl) ? ST_LEFT : ST_RIGHT;
            ST_LEFT:  if (trans)   state_d = ST_RIGHT;
            ST_RIGHT: if (trans)   state_d = ST_LEFT;
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs and held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev_q   <= 1'b0;
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            left_out    <= '0;
            right_out   <= '0;
            pair_valid  <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (bit_stb) ws_prev_q <= ws_s;
            if (trans) begin
                unique case (state_q)
                    ST_LEFT: begin
                        if (short_half) begin
                            frame_err   <= 1'b1;
                            have_left_q <= 1'b0;
                        end else begin
                            left_hold_q <= half_word;
                            have_left_q <= 1'b1;
                        end
                    end
                    ST_RIGHT: begin
                        have_left_q <= 1'b0;
                        if (short_half) begin
                            frame_err <= 1'b1;
                        end else if (have_left_q) begin
                            left_out   <= left_hold_q;
                            right_out  <= half_word;
                            pair_valid <= 1'b1;
                        end
                    end
                    default: have_left_q <= 1'b0;
                endcase
            end
        end
    end

    // R7
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7
    valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(state_q) == ST_RIGHT));

    // R9
    err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($past(state_q) == ST_LEFT || $past(state_q) == ST_RIGHT));

    // R8
    err_excludes_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && pair_valid));

    // R7
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
    localparam int HALF_SYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_out, right_out;
    logic        pair_valid, frame_err;

    int checks = 0;
    int errors = 0;
    int exp_err = 0;
    int seen_err = 0;
    logic [47:0] exp_q[$];

    always #5 clk = ~clk;

    audio_serial_rx u_audio_serial_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_in    (bclk_in),
        .ws_in      (ws_in),
        .sd_in      (sd_in),
        .fmt_sel    (fmt_sel),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid),
        .frame_err  (frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1 left-channel level per format code
    function automatic logic left_level(input logic [1:0] f);
        return (f != 2'b00);
    endfunction

    // R8 minimum slots per half
    function automatic int min_half(input logic [1:0] f);
        return (f == 2'b01 || f == 2'b11) ? 24 : 16;
    endfunction

    // Reference model of R3..R6
    function automatic logic [23:0] model(input logic [1:0] f, input logic [63:0] s, input int h);
        logic [23:0] r = '0;
        case (f)
            2'b10: for (int k = 0; k < 24; k++) if (k < h) r[23-k] = s[k];
            2'b00: for (int k = 0; k < 24; k++) if (k + 1 < h) r[23-k] = s[k+1];
            2'b01: for (int k = 0; k < 24; k++) if (h - 1 - k >= 0) r[k] = s[h-1-k];
            default: begin
                for (int k = 0; k < 16; k++) if (h - 1 - k >= 0) r[k] = s[h-1-k];
                for (int k = 16; k < 24; k++) r[k] = r[15];
            end
        endcase
        return r;
    endfunction

    task automatic drive_bit(input logic ws, input logic sd);
        bclk_in = 1'b0;
        ws_in   = ws;
        sd_in   = sd;
        repeat (HALF_SYS) @(negedge clk);
        bclk_in = 1'b1;
        repeat (HALF_SYS) @(negedge clk);
    endtask

    task automatic send_half(input logic ws, input logic [63:0] s, input int h);
        for (int j = 0; j < h; j++) drive_bit(ws, s[j]);
    endtask

    // driver: pushes expected pair, then sends both halves
    task automatic send_frame(input int hl, input int hr);
        logic [63:0] sl, sr;
        logic        ll;
        bit          el, er;
        sl = {$urandom, $urandom};
        sr = {$urandom, $urandom};
        ll = left_level(fmt_sel);
        el = (hl < min_half(fmt_sel));
        er = (hr < min_half(fmt_sel));
        exp_err += int'(el) + int'(er);
        if (!el && !er) exp_q.push_back({model(fmt_sel, sl, hl), model(fmt_sel, sr, hr)});
        send_half(ll, sl, hl);
        send_half(~ll, sr, hr);
    endtask

    task automatic start_session(input logic [1:0] f, input bit check_reset);
        rst_n   = 1'b0;
        fmt_sel = f;
        bclk_in = 1'b0;
        ws_in   = ~left_level(f);
        sd_in   = 1'b0;
        repeat (5) @(negedge clk);
        if (check_reset) begin
            // R10
            check(left_out == '0 && right_out == '0, "R10 reset samples", {left_out, right_out}, '0);
            check(!pair_valid, "R10 reset pair_valid", 48'(pair_valid), '0);
            check(!frame_err, "R10 reset frame_err", 48'(frame_err), '0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: short partial right half before first change, must be dropped
        for (int j = 0; j < 6; j++) drive_bit(~left_level(f), 1'b1);
    endtask

    task automatic end_session(input string tag);
        for (int j = 0; j < 3; j++) drive_bit(left_level(fmt_sel), 1'b0);
        repeat (20) @(negedge clk);
        // R7 / R9: every expected pair seen, none extra
        check(exp_q.size() == 0, {"R7 pairs drained ", tag}, 48'(exp_q.size()), '0);
        // R8: error pulse tally
        check(seen_err == exp_err, {"R8 frame_err count ", tag}, 48'(seen_err), 48'(exp_err));
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_err) seen_err++;
            if (pair_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 R8 unexpected pair", {left_out, right_out}, '0);
                end else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    // R1 R2 R3 R4 R5 R6 R7
                    check({left_out, right_out} == e, "R1-fmt R3 R4 R5 R6 pair data",
                          {left_out, right_out}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // I2S layout (R4), including exact minimum and a short left half
        start_session(2'b00, 1'b1);
        send_frame(32, 32);
        send_frame(20, 18);
        send_frame(16, 16);
        send_frame(10, 32);
        send_frame(32, 25);
        end_session("I2S");

        // Left-justified (R3): zero fill when short, junk past slot 23 ignored
        start_session(2'b10, 1'b0);
        send_frame(32, 32);
        send_frame(16, 16);
        send_frame(12, 32);
        send_frame(32, 32);
        send_frame(24, 24);
        end_session("LJ");

        // Right-justified 24 (R5)
        start_session(2'b01, 1'b0);
        send_frame(32, 32);
        send_frame(24, 24);
        send_frame(20, 32);
        send_frame(32, 30);
        end_session("RJ24");

        // Right-justified 16 with sign extension (R6), short right half (R8)
        start_session(2'b11, 1'b0);
        send_frame(24, 24);
        send_frame(32, 32);
        send_frame(32, 20);
        send_frame(32, 32);
        end_session("RJ16");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule